// File: doc/BRIEF.md
# Timestamp Record Matcher with Aging

This block keeps a small table of timestamp records captured from received precision-time frames. Each record holds a 3-bit hardware event tag, a 48-bit seconds count, a 32-bit nanoseconds count, a 64-bit clock identity, a 16-bit source port number and a 16-bit sequence id. Records enter through a single-cycle insert strobe and go into the lowest free slot. The hardware also notes, for every pair of live slots, which of the two arrived first.

A lookup request carries the header fields of a frame: the message type, clock identity, port number and sequence id, plus a flag that marks a version-1 frame. The block then scans the table one slot per cycle. If several records match, it returns the one that arrived first. It converts that record's seconds and nanoseconds into one 64-bit nanosecond value and frees the slot. When the scan reaches a record that has outlived its timeout, it frees that record without trying to match it. A parser upstream supplies the header fields, and a FIFO upstream supplies the records.

Top module: `ts_record_matcher`

## Requirements
- R1: The stored 3-bit tag is translated to a 4-bit message type before the compare. Tag 1 becomes 0 (sync), tag 2 becomes 2 (peer delay request), tag 3 becomes 3 (peer delay response) and tag 4 becomes 1 (delay request). Tags 0, 5, 6 and 7 become 0xF, and a record with such a tag never matches, even when the request's type is 0xF.
- R2: A record matches only when all four fields are equal: message type, clock identity, port number and sequence id. A difference in any one field is a miss.
- R3: A request with the version-1 flag set always misses.
- R4: On a hit, `lk_ts` equals seconds × 1,000,000,000 + nanoseconds, truncated to 64 bits. On a miss, `lk_hit` is 0 and `lk_ts` is 0.
- R5: A record that hits is freed, so a repeat of the same lookup misses.
- R6: A record's age counts `tick` pulses since its insert, and the record is expired once its age exceeds TIMEOUT_TICKS. An expired record never matches. Only a lookup scan frees it; until a scan reaches it, it keeps its slot.
- R7: When several records match, the one inserted first is returned and freed, whatever slots the records occupy. The newer records stay in the table.
- R8: An insert that finds every slot occupied is refused. `ins_full_err` is 1 in the cycle after that insert, and the record is not stored. An accepted insert leaves `ins_full_err` at 0.
- R9: `lk_done` pulses for one cycle, ENTRIES+1 clock edges after the edge that takes the request. `lk_busy` is high in between. A request made while busy is ignored.
- R10: After reset the table is empty and `lk_busy`, `lk_done`, `lk_hit`, `lk_ts` and `ins_full_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Aging tick, one-cycle pulses |
| ins_valid | input | 1 | Insert strobe for one record |
| ins_tag | input | 3 | Hardware event tag |
| ins_sec | input | 48 | Seconds |
| ins_nsec | input | 32 | Nanoseconds |
| ins_clk_id | input | 64 | Clock identity |
| ins_port | input | 16 | Source port number |
| ins_seq | input | 16 | Sequence id |
| ins_full_err | output | 1 | Previous insert refused, table full |
| lk_req | input | 1 | Lookup request strobe |
| lk_v1 | input | 1 | Request comes from a version-1 frame |
| lk_msg | input | 4 | Message type of the frame |
| lk_clk_id | input | 64 | Clock identity of the frame |
| lk_port | input | 16 | Source port number of the frame |
| lk_seq | input | 16 | Sequence id of the frame |
| lk_busy | output | 1 | Scan in progress |
| lk_done | output | 1 | One-cycle pulse, lookup result valid |
| lk_hit | output | 1 | Lookup found a record |
| lk_ts | output | 64 | Timestamp in nanoseconds, 0 on a miss |

## Verification
The bench builds the block with ENTRIES=4 and TIMEOUT_TICKS=3. With only four slots, a few inserts fill the table, which makes the refusal path and slot reuse cheap to reach. It also lets a newer record land in a lower slot than an older one with the same header, so the arrival-order choice is exercised. A timeout of three ticks puts both sides of the expiry boundary, three ticks and four ticks, within a handful of cycles.

// File: rtl/ptsm_pkg.sv
package ptsm_pkg;

    localparam int TAG_W   = 3;
    localparam int MSG_W   = 4;
    localparam int SEC_W   = 48;
    localparam int NSEC_W  = 32;
    localparam int CLKID_W = 64;
    localparam int PORT_W  = 16;
    localparam int SEQ_W   = 16;
    localparam int TS_W    = 64;

    localparam logic [MSG_W-1:0] MSG_INVALID = 4'hF;
    localparam logic [TS_W-1:0]  NS_PER_SEC  = 64'd1000000000;

    typedef struct packed {
        logic [TAG_W-1:0]   tag;
        logic [SEC_W-1:0]   sec;
        logic [NSEC_W-1:0]  nsec;
        logic [CLKID_W-1:0] clk_id;
        logic [PORT_W-1:0]  port_num;
        logic [SEQ_W-1:0]   seq_id;
    } ts_rec_t;

    typedef struct packed {
        logic               v1;
        logic [MSG_W-1:0]   msg;
        logic [CLKID_W-1:0] clk_id;
        logic [PORT_W-1:0]  port_num;
        logic [SEQ_W-1:0]   seq_id;
    } lk_key_t;

    typedef enum logic [1:0] {
        SC_IDLE = 2'd0,
        SC_SCAN = 2'd1,
        SC_FIN  = 2'd2
    } scan_st_e;

    // hardware event tag to protocol message type
    function automatic logic [MSG_W-1:0] tag_to_msg(input logic [TAG_W-1:0] t);
        logic [MSG_W-1:0] m;
        case (t)
            3'd1:    m = 4'h0;
            3'd2:    m = 4'h2;
            3'd3:    m = 4'h3;
            3'd4:    m = 4'h1;
            default: m = MSG_INVALID;
        endcase
        return m;
    endfunction

    function automatic logic key_hit(input ts_rec_t r, input lk_key_t k);
        logic [MSG_W-1:0] m;
        m = tag_to_msg(r.tag);
        return !k.v1 && (m != MSG_INVALID) && (m == k.msg) &&
               (r.clk_id == k.clk_id) && (r.port_num == k.port_num) &&
               (r.seq_id == k.seq_id);
    endfunction

endpackage

// File: rtl/ptsm_slot.sv
module ptsm_slot
    import ptsm_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 1000
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    tick,
    input  logic    load,
    input  ts_rec_t load_rec,
    input  logic    drop,
    output logic    occupied,
    output logic    expired,
    output ts_rec_t rec
);

    localparam int AGE_MAX = TIMEOUT_TICKS + 1;
    localparam int AGE_W   = $clog2(AGE_MAX + 1);
    localparam logic [AGE_W-1:0] AGE_LIM = AGE_W'(TIMEOUT_TICKS);
    localparam logic [AGE_W-1:0] AGE_SAT = AGE_W'(AGE_MAX);

    logic [AGE_W-1:0] age;

    always_ff @(posedge clk) begin
        if (rst) begin
            occupied <= 1'b0;
            age      <= '0;
        end else begin
            if (load) begin
                occupied <= 1'b1;
                age      <= '0;
            end else begin
                if (drop)
                    occupied <= 1'b0;
                if (tick && age != AGE_SAT)
                    age <= age + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (load)
            rec <= load_rec;
    end

    assign expired = occupied && (age > AGE_LIM);

    // R8: a record only ever goes into a free slot
    a_r8_load_into_free: assert property (@(posedge clk) disable iff (rst)
        load |-> !occupied);

    // R6: a freshly loaded record is not yet expired
    a_r6_fresh_not_expired: assert property (@(posedge clk) disable iff (rst)
        load |=> (occupied && !expired));

    // R5: only a live record can be freed
    a_r5_drop_live: assert property (@(posedge clk) disable iff (rst)
        drop |-> occupied);

endmodule

// File: rtl/ptsm_age_order.sv
module ptsm_age_order #(
    parameter int N = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N-1:0]        load_vec,
    input  logic [N-1:0]        occ,
    output logic [N-1:0][N-1:0] older
);

    // older[i][j] == 1 : slot i was filled before slot j
    for (genvar gi = 0; gi < N; gi++) begin : g_row
        for (genvar gj = 0; gj < N; gj++) begin : g_col
            if (gi == gj) begin : g_diag
                assign older[gi][gj] = 1'b0;
            end else begin : g_cell
                always_ff @(posedge clk) begin
                    if (rst)
                        older[gi][gj] <= 1'b0;
                    else if (load_vec[gi])
                        older[gi][gj] <= 1'b0;
                    else if (load_vec[gj])
                        older[gi][gj] <= occ[gi];
                end
                if (gi < gj) begin : g_chk
                    // R7: every live pair has exactly one elder
                    a_r7_order_antisym: assert property (@(posedge clk) disable iff (rst)
                        (occ[gi] && occ[gj]) |-> (older[gi][gj] != older[gj][gi]));
                end
            end
        end
    end

    // R8: at most one slot loads per cycle
    a_r8_single_load: assert property (@(posedge clk) disable iff (rst)
        $onehot0(load_vec));

endmodule

// File: rtl/ptsm_ns_conv.sv
module ptsm_ns_conv
    import ptsm_pkg::*;
(
    input  logic [SEC_W-1:0]  sec,
    input  logic [NSEC_W-1:0] nsec,
    output logic [TS_W-1:0]   ts_ns
);

    logic [TS_W-1:0] sec_ext;
    logic [TS_W-1:0] nsec_ext;

    assign sec_ext  = TS_W'(sec);
    assign nsec_ext = TS_W'(nsec);
    assign ts_ns    = (sec_ext * NS_PER_SEC) + nsec_ext;

endmodule

// File: rtl/ts_record_matcher.sv
module ts_record_matcher
    import ptsm_pkg::*;
#(
    parameter int ENTRIES       = 16,
    parameter int TIMEOUT_TICKS = 1000
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         ins_valid,
    input  logic [2:0]   ins_tag,
    input  logic [47:0]  ins_sec,
    input  logic [31:0]  ins_nsec,
    input  logic [63:0]  ins_clk_id,
    input  logic [15:0]  ins_port,
    input  logic [15:0]  ins_seq,
    output logic         ins_full_err,
    input  logic         lk_req,
    input  logic         lk_v1,
    input  logic [3:0]   lk_msg,
    input  logic [63:0]  lk_clk_id,
    input  logic [15:0]  lk_port,
    input  logic [15:0]  lk_seq,
    output logic         lk_busy,
    output logic         lk_done,
    output logic         lk_hit,
    output logic [63:0]  lk_ts
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    logic [ENTRIES-1:0]          occ;
    logic [ENTRIES-1:0]          expd;
    logic [ENTRIES-1:0]          load_vec;
    logic [ENTRIES-1:0]          drop_vec;
    ts_rec_t [ENTRIES-1:0]       recs;
    logic [ENTRIES-1:0][ENTRIES-1:0] older;
    ts_rec_t                     new_rec;

    scan_st_e                    st;
    logic [IDX_W-1:0]            ptr;
    logic [IDX_W-1:0]            cand;
    logic                        cand_v;
    lk_key_t                     key;

    logic                        free_any;
    logic [IDX_W-1:0]            free_idx;
    logic                        cur_hit;
    logic                        take;
    logic [TS_W-1:0]             conv_ts;

    assign new_rec = '{tag: ins_tag, sec: ins_sec, nsec: ins_nsec,
                       clk_id: ins_clk_id, port_num: ins_port, seq_id: ins_seq};

    // lowest free slot
    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!occ[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        load_vec = '0;
        if (ins_valid && free_any)
            load_vec[free_idx] = 1'b1;
    end

    // compare the slot under the scan pointer
    assign cur_hit = occ[ptr] && !expd[ptr] && key_hit(recs[ptr], key);
    assign take    = (st == SC_SCAN) && cur_hit && (!cand_v || older[ptr][cand]);

    always_comb begin
        drop_vec = '0;
        if (st == SC_SCAN && occ[ptr] && expd[ptr])
            drop_vec[ptr] = 1'b1;
        if (st == SC_FIN && cand_v)
            drop_vec[cand] = 1'b1;
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        ptsm_slot #(
            .TIMEOUT_TICKS(TIMEOUT_TICKS)
        ) i_slot (
            .clk      (clk),
            .rst      (rst),
            .tick     (tick),
            .load     (load_vec[g]),
            .load_rec (new_rec),
            .drop     (drop_vec[g]),
            .occupied (occ[g]),
            .expired  (expd[g]),
            .rec      (recs[g])
        );
    end

    ptsm_age_order #(
        .N(ENTRIES)
    ) i_order (
        .clk      (clk),
        .rst      (rst),
        .load_vec (load_vec),
        .occ      (occ),
        .older    (older)
    );

    ptsm_ns_conv i_conv (
        .sec   (recs[cand].sec),
        .nsec  (recs[cand].nsec),
        .ts_ns (conv_ts)
    );

    always_ff @(posedge clk) begin
        if (rst)
            ins_full_err <= 1'b0;
        else
            ins_full_err <= ins_valid && !free_any;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= SC_IDLE;
            ptr     <= '0;
            cand    <= '0;
            cand_v  <= 1'b0;
            key     <= '0;
            lk_done <= 1'b0;
            lk_hit  <= 1'b0;
            lk_ts   <= '0;
        end else begin
            lk_done <= 1'b0;
            case (st)
                SC_IDLE: begin
                    if (lk_req) begin
                        key    <= '{v1: lk_v1, msg: lk_msg, clk_id: lk_clk_id,
                                    port_num: lk_port, seq_id: lk_seq};
                        ptr    <= '0;
                        cand_v <= 1'b0;
                        st     <= SC_SCAN;
                    end
                end
                SC_SCAN: begin
                    if (take) begin
                        cand_v <= 1'b1;
                        cand   <= ptr;
                    end
                    if (ptr == LAST_IDX)
                        st <= SC_FIN;
                    else
                        ptr <= ptr + 1'b1;
                end
                SC_FIN: begin
                    lk_done <= 1'b1;
                    lk_hit  <= cand_v;
                    lk_ts   <= cand_v ? conv_ts : '0;
                    st      <= SC_IDLE;
                end
                default: st <= SC_IDLE;
            endcase
        end
    end

    assign lk_busy = (st != SC_IDLE);

    // R4: a miss reports zero
    a_r4_miss_zero: assert property (@(posedge clk) disable iff (rst)
        (lk_done && !lk_hit) |-> (lk_ts == '0));

    // R9: done is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        lk_done |=> !lk_done);

    // R9: a scan only starts from a request
    a_r9_start_on_req: assert property (@(posedge clk) disable iff (rst)
        $rose(lk_busy) |-> $past(lk_req));

    // R9: busy ends together with the done pulse
    a_r9_busy_ends_done: assert property (@(posedge clk) disable iff (rst)
        $fell(lk_busy) |-> lk_done);

    // R8: a refusal always follows an insert attempt
    a_r8_err_from_insert: assert property (@(posedge clk) disable iff (rst)
        ins_full_err |-> $past(ins_valid));

endmodule

// File: tb/test_ts_record_matcher.sv
module test_ts_record_matcher;

    localparam int CLK_PERIOD = 10;
    localparam int N   = 4;
    localparam int TMO = 3;
    localparam int NV  = 12;

    typedef struct packed {
        logic [2:0]  tag;
        logic [3:0]  msg;
        logic        v1;
        logic [1:0]  bad;   // 0 none, 1 clock id, 2 port, 3 sequence
        logic [47:0] sec;
        logic [31:0] ns;
        logic        hit;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{3'd1, 4'd0, 1'b0, 2'd0, 48'd5,          32'd7,         1'b1}, // R1 sync
        '{3'd2, 4'd2, 1'b0, 2'd0, 48'd12,         32'd999999999, 1'b1}, // R1 peer req
        '{3'd3, 4'd3, 1'b0, 2'd0, 48'd1700000000, 32'd123456789, 1'b1}, // R1 peer resp, R4
        '{3'd4, 4'd1, 1'b0, 2'd0, 48'd0,          32'd42,        1'b1}, // R1 delay req
        '{3'd1, 4'd1, 1'b0, 2'd0, 48'd3,          32'd3,         1'b0}, // R1 wrong type
        '{3'd5, 4'd15,1'b0, 2'd0, 48'd3,          32'd3,         1'b0}, // R1 bad tag
        '{3'd0, 4'd15,1'b0, 2'd0, 48'd3,          32'd3,         1'b0}, // R1 bad tag
        '{3'd1, 4'd0, 1'b0, 2'd1, 48'd9,          32'd9,         1'b0}, // R2 clock id
        '{3'd1, 4'd0, 1'b0, 2'd2, 48'd9,          32'd9,         1'b0}, // R2 port
        '{3'd1, 4'd0, 1'b0, 2'd3, 48'd9,          32'd9,         1'b0}, // R2 sequence
        '{3'd2, 4'd2, 1'b1, 2'd0, 48'd9,          32'd9,         1'b0}, // R3 version 1
        '{3'd4, 4'd1, 1'b0, 2'd0, 48'hFFFFFFFFFFFF, 32'd1,       1'b1}  // R4 wrap
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        ins_valid = 1'b0;
    logic [2:0]  ins_tag = '0;
    logic [47:0] ins_sec = '0;
    logic [31:0] ins_nsec = '0;
    logic [63:0] ins_clk_id = '0;
    logic [15:0] ins_port = '0;
    logic [15:0] ins_seq = '0;
    logic        ins_full_err;
    logic        lk_req = 1'b0;
    logic        lk_v1 = 1'b0;
    logic [3:0]  lk_msg = '0;
    logic [63:0] lk_clk_id = '0;
    logic [15:0] lk_port = '0;
    logic [15:0] lk_seq = '0;
    logic        lk_busy;
    logic        lk_done;
    logic        lk_hit;
    logic [63:0] lk_ts;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    ts_record_matcher #(
        .ENTRIES(N),
        .TIMEOUT_TICKS(TMO)
    ) i_ts_record_matcher (
        .clk(clk), .rst(rst), .tick(tick),
        .ins_valid(ins_valid), .ins_tag(ins_tag), .ins_sec(ins_sec),
        .ins_nsec(ins_nsec), .ins_clk_id(ins_clk_id), .ins_port(ins_port),
        .ins_seq(ins_seq), .ins_full_err(ins_full_err),
        .lk_req(lk_req), .lk_v1(lk_v1), .lk_msg(lk_msg), .lk_clk_id(lk_clk_id),
        .lk_port(lk_port), .lk_seq(lk_seq), .lk_busy(lk_busy),
        .lk_done(lk_done), .lk_hit(lk_hit), .lk_ts(lk_ts)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [63:0] exp_ts(input logic [47:0] s, input logic [31:0] n);
        return ({16'd0, s} * 64'd1000000000) + {32'd0, n};
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
        end
    endtask

    task automatic do_ins(input logic [2:0] tg, input logic [47:0] s, input logic [31:0] n,
                          input logic [63:0] cid, input logic [15:0] pn, input logic [15:0] sq,
                          input logic exp_err);
        @(negedge clk);
        ins_valid = 1'b1; ins_tag = tg; ins_sec = s; ins_nsec = n;
        ins_clk_id = cid; ins_port = pn; ins_seq = sq;
        @(negedge clk);
        ins_valid = 1'b0;
        check(ins_full_err == exp_err, "R8 insert flag", 64'(ins_full_err), 64'(exp_err));
    endtask

    task automatic do_lk(input logic v1, input logic [3:0] m, input logic [63:0] cid,
                         input logic [15:0] pn, input logic [15:0] sq,
                         output logic hit, output logic [63:0] ts, output int cyc);
        @(negedge clk);
        lk_req = 1'b1; lk_v1 = v1; lk_msg = m; lk_clk_id = cid; lk_port = pn; lk_seq = sq;
        @(posedge clk);
        @(negedge clk);
        lk_req = 1'b0;
        cyc = 0;
        while (!lk_done && cyc < 100) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
        end
        hit = lk_hit;
        ts  = lk_ts;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic flush();
        logic h; logic [63:0] t; int c;
        ticks(TMO + 1);
        do_lk(1'b1, 4'd0, 64'd0, 16'd0, 16'd0, h, t, c);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic h; logic [63:0] t; int c;
        logic [63:0] cid; logic [15:0] pn; logic [15:0] sq;
        int extra;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10 reset state
        check(lk_busy == 1'b0, "R10 busy", 64'(lk_busy), 64'd0);
        check(lk_done == 1'b0 && lk_hit == 1'b0, "R10 done/hit", 64'({lk_done, lk_hit}), 64'd0);
        check(lk_ts == 64'd0, "R10 ts", lk_ts, 64'd0);
        check(ins_full_err == 1'b0, "R10 err", 64'(ins_full_err), 64'd0);
        do_lk(1'b0, 4'd0, 64'd0, 16'd0, 16'd0, h, t, c);
        check(h == 1'b0, "R10 empty lookup", 64'(h), 64'd0);

        // vector table: R1 R2 R3 R4
        for (int i = 0; i < NV; i++) begin
            cid = 64'hC0DE_0000_0000_0000 | 64'(i);
            pn  = 16'h0100 + 16'(i);
            sq  = 16'h2000 + 16'(i);
            do_ins(VECS[i].tag, VECS[i].sec, VECS[i].ns, cid, pn, sq, 1'b0);
            do_lk(VECS[i].v1, VECS[i].msg,
                  (VECS[i].bad == 2'd1) ? cid ^ 64'd1 : cid,
                  (VECS[i].bad == 2'd2) ? pn ^ 16'd1 : pn,
                  (VECS[i].bad == 2'd3) ? sq ^ 16'd1 : sq, h, t, c);
            check(h == VECS[i].hit,
                  (VECS[i].bad != 0) ? "R2 hit" : (VECS[i].v1 ? "R3 hit" : "R1 hit"),
                  64'(h), 64'(VECS[i].hit));
            check(t == (VECS[i].hit ? exp_ts(VECS[i].sec, VECS[i].ns) : 64'd0), "R4 ts",
                  t, VECS[i].hit ? exp_ts(VECS[i].sec, VECS[i].ns) : 64'd0);
            if (i == 0)
                check(c == N + 1, "R9 latency", 64'(c), 64'(N + 1));
            flush();
        end

        // R5 hit frees the entry
        do_ins(3'd1, 48'd77, 32'd1, 64'h55, 16'd5, 16'd6, 1'b0);
        do_lk(1'b0, 4'd0, 64'h55, 16'd5, 16'd6, h, t, c);
        check(h == 1'b1, "R5 first hit", 64'(h), 64'd1);
        do_lk(1'b0, 4'd0, 64'h55, 16'd5, 16'd6, h, t, c);
        check(h == 1'b0, "R5 repeat miss", 64'(h), 64'd0);

        // R6 expiry boundary
        do_ins(3'd2, 48'd10, 32'd10, 64'h61, 16'd1, 16'd1, 1'b0);
        ticks(TMO);
        do_lk(1'b0, 4'd2, 64'h61, 16'd1, 16'd1, h, t, c);
        check(h == 1'b1, "R6 at limit still hits", 64'(h), 64'd1);
        do_ins(3'd2, 48'd10, 32'd10, 64'h62, 16'd1, 16'd1, 1'b0);
        ticks(TMO + 1);
        do_lk(1'b0, 4'd2, 64'h62, 16'd1, 16'd1, h, t, c);
        check(h == 1'b0, "R6 past limit misses", 64'(h), 64'd0);

        // R8 fill: the scan above freed the expired entry, so all N fit
        for (int k = 0; k < N; k++)
            do_ins(3'd1, 48'd1, 32'(k), 64'h70 + 64'(k), 16'd7, 16'd7, 1'b0);
        do_ins(3'd1, 48'd1, 32'd9, 64'h7F, 16'd7, 16'd7, 1'b1);
        do_lk(1'b0, 4'd0, 64'h7F, 16'd7, 16'd7, h, t, c);
        check(h == 1'b0, "R8 refused not stored", 64'(h), 64'd0);
        do_lk(1'b0, 4'd0, 64'h70, 16'd7, 16'd7, h, t, c);
        check(h == 1'b1 && t == exp_ts(48'd1, 32'd0), "R8 stored kept", t, exp_ts(48'd1, 32'd0));

        // R6 expired entries hold slots until a scan
        do_ins(3'd1, 48'd1, 32'd0, 64'h70, 16'd7, 16'd7, 1'b0);
        ticks(TMO + 1);
        do_ins(3'd1, 48'd2, 32'd0, 64'h80, 16'd8, 16'd8, 1'b1);
        do_lk(1'b1, 4'd0, 64'd0, 16'd0, 16'd0, h, t, c);
        do_ins(3'd1, 48'd2, 32'd0, 64'h80, 16'd8, 16'd8, 1'b0);
        check(1'b1, "R6 scan frees", 64'd0, 64'd0);
        flush();

        // R7 arrival order beats slot order
        do_ins(3'd3, 48'd1, 32'd1, 64'h90, 16'd9, 16'd9, 1'b0);   // slot 0
        do_ins(3'd1, 48'd2, 32'd2, 64'h91, 16'd9, 16'd9, 1'b0);   // slot 1, older H
        do_lk(1'b0, 4'd3, 64'h90, 16'd9, 16'd9, h, t, c);         // frees slot 0
        do_ins(3'd1, 48'd3, 32'd3, 64'h91, 16'd9, 16'd9, 1'b0);   // slot 0, newer H
        do_lk(1'b0, 4'd0, 64'h91, 16'd9, 16'd9, h, t, c);
        check(h && t == exp_ts(48'd2, 32'd2), "R7 oldest first", t, exp_ts(48'd2, 32'd2));
        do_lk(1'b0, 4'd0, 64'h91, 16'd9, 16'd9, h, t, c);
        check(h && t == exp_ts(48'd3, 32'd3), "R7 newer next", t, exp_ts(48'd3, 32'd3));

        // R9 request during a scan is ignored
        do_ins(3'd1, 48'd4, 32'd4, 64'hA0, 16'd1, 16'd2, 1'b0);
        @(negedge clk);
        lk_req = 1'b1; lk_v1 = 1'b0; lk_msg = 4'd0; lk_clk_id = 64'hDEAD;
        lk_port = 16'd1; lk_seq = 16'd2;
        @(negedge clk);
        lk_req = 1'b0;
        @(negedge clk);
        check(lk_busy == 1'b1, "R9 busy in scan", 64'(lk_busy), 64'd1);
        lk_req = 1'b1; lk_clk_id = 64'hA0;
        @(negedge clk);
        lk_req = 1'b0;
        c = 0;
        while (!lk_done && c < 100) begin
            @(negedge clk);
            c++;
        end
        check(lk_hit == 1'b0, "R9 first request wins", 64'(lk_hit), 64'd0);
        extra = 0;
        for (int k = 0; k < N + 3; k++) begin
            @(negedge clk);
            if (lk_done) extra++;
        end
        check(extra == 0, "R9 no second scan", 64'(extra), 64'd0);
        do_lk(1'b0, 4'd0, 64'hA0, 16'd1, 16'd2, h, t, c);
        check(h == 1'b1, "R9 entry untouched", 64'(h), 64'd1);

        summary();
    end

endmodule